// File: doc/BRIEF.md
# Ring Interrupt Credit Moderator

This block moderates interrupts for one descriptor ring. It keeps a count of the descriptors that the device has completed and that software has not yet consumed. Each completion pulse from the device side adds one to the count. Software hands consumed credits back with a single write of the amount it processed, and that amount is taken off the count.

An interrupt request is raised when the ring is idle and unmasked and a completion arrives. After any request the ring masks itself. Completions that arrive while the ring is masked only add to the count. A credit return that empties the count clears the self-mask but raises no request. A credit return that leaves work behind raises a new request, and the ring stays masked. This self-mask belongs to the ring alone. It has no link to any per-vector mask held in the system's interrupt controller.

Top module: `ring_irq_credit`

## Requirements
- R1: After reset the credit count is 0, the auto-mask flag is clear and the interrupt request is low.
- R2: A completion pulse with no credit write raises the credit count by exactly one on the following clock edge.
- R3: A completion with no credit write, while the ring is unmasked, gives a one-cycle interrupt request in the next cycle and sets the auto-mask flag in that same cycle.
- R4: While the ring is masked, completions without a credit write only raise the count and give no interrupt request.
- R5: A credit write subtracts the written value from the count on the following edge.
- R6: A credit write larger than the count plus any same-cycle completion leaves the count at 0.
- R7: A credit write whose result is a count of 0 clears the auto-mask flag and gives no interrupt request.
- R8: A credit write whose result is a nonzero count gives a one-cycle interrupt request and leaves the auto-mask flag set.
- R9: When a completion and a credit write fall in the same cycle, the new count is count + 1 - returned (floored at 0), and R7 or R8 applies to that result.
- R10: The interrupt request is high for one cycle only, unless another completion or credit write starts a new request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmplPulse | input | 1 | One descriptor completed in this cycle |
| creditWrEn | input | 1 | Software credit return write strobe |
| creditWrVal | input | 32 | Number of credits returned |
| irqPulse | output | 1 | Interrupt request, one cycle wide |
| creditCount | output | 32 | Credits still outstanding |
| autoMasked | output | 1 | Ring auto-mask flag |

## Verification
Every output is registered. The count, the mask flag and the request therefore all reflect the inputs of a cycle exactly one clock edge later, and nothing is due sooner or later than that. The bench drives inputs on the falling edge. It computes the expected state for the next rising edge with a reference model, and it compares all three outputs on the following falling edge, one edge after the stimulus. Directed sequences cover the first request, masked completions, partial and full returns, over-returns and same-cycle collisions. A seeded random run then mixes all of these.

// File: rtl/ring_irq_credit_pkg.sv
package ring_irq_credit_pkg;
  localparam int CNT_W = 32;

  // Strobes from control to the credit datapath
  typedef struct packed {
    logic countUp;
    logic countDown;
  } credStrobe_t;
endpackage

// File: rtl/ring_irq_credit_dp.sv
module ring_irq_credit_dp
  import ring_irq_credit_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rstN,
  input  credStrobe_t  strb,
  input  logic [W-1:0] retVal,
  output logic         nextZero,
  output logic [W-1:0] count
);
  localparam int SW = W + 1;
  localparam logic [SW-1:0] MAX_CNT = {1'b0, {W{1'b1}}};

  logic [SW-1:0] sumUp;
  logic [SW-1:0] retExt;
  logic [SW-1:0] diff;
  logic [W-1:0]  countNext;

  always_comb begin
    sumUp  = {1'b0, count} + {{W{1'b0}}, strb.countUp};
    retExt = strb.countDown ? {1'b0, retVal} : '0;
    if (sumUp <= retExt) diff = '0;
    else                 diff = sumUp - retExt;
    // clamp at the top instead of wrapping
    if (diff > MAX_CNT) countNext = {W{1'b1}};
    else                countNext = diff[W-1:0];
    nextZero = (countNext == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) count <= '0;
    else       count <= countNext;
  end

  assert_increment_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.countUp) && !$past(strb.countDown) && ($past(count) != {W{1'b1}}))
      |-> (count == $past(count) + 1'b1));

  assert_subtract_R5: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(strb.countUp) && $past(strb.countDown) && ($past(retVal) <= $past(count)))
      |-> (count == $past(count) - $past(retVal)));

  assert_floor_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(strb.countDown) && !$past(strb.countUp) && ($past(retVal) > $past(count)))
      |-> (count == '0));
endmodule

// File: rtl/ring_irq_credit_ctrl.sv
module ring_irq_credit_ctrl
  import ring_irq_credit_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmplPulse,
  input  logic        creditWrEn,
  input  logic        nextZero,
  output credStrobe_t strb,
  output logic        irqPulse,
  output logic        autoMasked
);
  logic fireNext;
  logic maskNext;

  always_comb begin
    strb.countUp   = cmplPulse;
    strb.countDown = creditWrEn;
    fireNext = 1'b0;
    maskNext = autoMasked;
    if (creditWrEn) begin
      if (nextZero) begin
        maskNext = 1'b0;
      end else begin
        fireNext = 1'b1;
        maskNext = 1'b1;
      end
    end else if (cmplPulse && !autoMasked) begin
      fireNext = 1'b1;
      maskNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqPulse   <= 1'b0;
      autoMasked <= 1'b0;
    end else begin
      irqPulse   <= fireNext;
      autoMasked <= maskNext;
    end
  end

  assert_first_fire_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(cmplPulse) && !$past(creditWrEn) && !$past(autoMasked))
      |-> (irqPulse && autoMasked));

  assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(autoMasked) && !$past(creditWrEn)) |-> !irqPulse);

  assert_fire_masks_R8: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |-> autoMasked);

  assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqPulse && !cmplPulse && !creditWrEn) |=> !irqPulse);
endmodule

// File: rtl/ring_irq_credit.sv
module ring_irq_credit
  import ring_irq_credit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmplPulse,
  input  logic             creditWrEn,
  input  logic [CNT_W-1:0] creditWrVal,
  output logic             irqPulse,
  output logic [CNT_W-1:0] creditCount,
  output logic             autoMasked
);
  credStrobe_t strb;
  logic        nextZero;

  ring_irq_credit_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .cmplPulse  (cmplPulse),
    .creditWrEn (creditWrEn),
    .nextZero   (nextZero),
    .strb       (strb),
    .irqPulse   (irqPulse),
    .autoMasked (autoMasked)
  );

  ring_irq_credit_dp #(.W(CNT_W)) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .retVal   (creditWrVal),
    .nextZero (nextZero),
    .count    (creditCount)
  );

  assert_empty_unmask_R7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(creditWrEn) && (creditCount == '0)) |-> (!irqPulse && !autoMasked));
endmodule

// File: tb/ring_irq_credit_test.sv
module ring_irq_credit_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmplPulse = 1'b0;
  logic        creditWrEn = 1'b0;
  logic [31:0] creditWrVal = '0;
  logic        irqPulse;
  logic [31:0] creditCount;
  logic        autoMasked;

  int checks = 0;
  int errors = 0;

  // reference state
  longint unsigned mCnt = 0;
  bit mMask = 0;
  bit mIrq = 0;

  ring_irq_credit uut (
    .clk(clk), .rstN(rstN), .cmplPulse(cmplPulse), .creditWrEn(creditWrEn),
    .creditWrVal(creditWrVal), .irqPulse(irqPulse), .creditCount(creditCount),
    .autoMasked(autoMasked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint unsigned nextCount(longint unsigned c, bit up, bit wr, longint unsigned v);
    longint unsigned s;
    s = c + (up ? 1 : 0);
    if (!wr) return s;
    if (v >= s) return 0;
    return s - v;
  endfunction

  task automatic check(string req, logic [31:0] cnt, bit msk, bit irq);
    checks++;
    if (creditCount !== cnt || autoMasked !== msk || irqPulse !== irq) begin
      errors++;
      $display("FAIL %s: count=%0d mask=%0b irq=%0b expected count=%0d mask=%0b irq=%0b",
               req, creditCount, autoMasked, irqPulse, cnt, msk, irq);
    end
  endtask

  // Drive one cycle (called at a falling edge), check one edge later
  task automatic step(bit up, bit wr, logic [31:0] v, string req);
    longint unsigned n;
    cmplPulse = up; creditWrEn = wr; creditWrVal = v;
    n = nextCount(mCnt, up, wr, v);
    mIrq = 0;
    if (wr) begin
      if (n == 0) mMask = 0;
      else begin mIrq = 1; mMask = 1; end
    end else if (up && !mMask) begin
      mIrq = 1; mMask = 1;
    end
    mCnt = n;
    @(negedge clk);
    cmplPulse = 0; creditWrEn = 0; creditWrVal = '0;
    check(req, mCnt[31:0], mMask, mIrq);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", 32'd0, 1'b0, 1'b0);

    step(1, 0, 0, "R3");      // first completion fires
    step(0, 0, 0, "R10");     // pulse ends
    step(1, 0, 0, "R4");      // masked, count 2
    step(1, 0, 0, "R2");      // count 3
    step(0, 1, 1, "R8");      // partial return re-fires
    step(0, 0, 0, "R10");
    step(0, 1, 2, "R7");      // full return, unmask silently
    step(0, 0, 0, "R1");
    step(1, 0, 0, "R3");      // fires again after rearm
    step(1, 0, 0, "R4");
    step(0, 1, 1, "R5");      // count 1, re-fire
    step(0, 1, 50, "R6");     // over-return saturates, unmask
    step(1, 1, 0, "R9");      // collision, net 1 -> fire
    step(1, 1, 1, "R9");      // collision, net 1 -> fire
    step(1, 1, 2, "R9");      // collision, net 0 -> unmask
    step(1, 1, 9, "R6");      // collision over-return
    step(1, 0, 0, "R3");

    for (int i = 0; i < 3000; i++) begin
      bit up, wr;
      logic [31:0] v;
      up = ($urandom % 2) == 1;
      wr = ($urandom % 5) == 0;
      v  = 32'($urandom % (mCnt + 3));
      step(up, wr, v, wr ? (up ? "R9" : "R5") : (up ? "R2" : "R10"));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule